// File: doc/BRIEF.md
# DMA Interrupt Status and Clear Register

This block gathers interrupt events from a transmit DMA path and a receive DMA path into one status word. Each event is held in a sticky bit until software writes a 1 to that bit position; a 0 in the written word leaves the bit as it is. The same read word also carries live copies of the receive FIFO read pointer, the transmit ring read pointer and the sequence number of the receive message at the head of the queue. Software can therefore learn both why it was interrupted and where the rings stand in one access.

A single interrupt line is formed from the set status bits and a control word supplied by the DMA control register. Some bits are gated by enables in that word. Others, including the whole error group, always reach the line. Three conditions are treated as fatal: a memory error, a transmit abort and a receive overflow. While any of them is latched, a halt output tells the DMA engines to stop.

The receive threshold event is not a pulse input. The block raises it itself in every cycle in which the receive FIFO entry count differs from the depth field of the control word.

Top module: `irq_status_ctl`

## Requirements
- R1: While reset is held, and in the first cycle after it, all eight status bits read 0 and both `irq` and `dma_halt` are low.
- R2: Event status bit positions are: 0 transmit ring empty, 1 transmit packet sent with interrupt request, 2 link failure, 3 memory error, 4 transmit abort, 5 receive threshold, 6 receive underflow, 7 receive overflow. A one-cycle event pulse sets its bit at the next clock edge, and the bit stays set with no further activity.
- R3: A write with `reg_wr_en` high clears, at the next edge, each status bit whose position in `reg_wdata[7:0]` holds 1. Bits whose position holds 0 keep their value.
- R4: When an event for a bit arrives in the same cycle as a write that would clear that bit, the bit is set after the edge.
- R5: In every cycle where `rx_fifo_count` differs from the depth field `dma_ctrl[8:4]`, status bit 5 is set at the next edge. When the two are equal, nothing sets bit 5.
- R6: `reg_rdata[11:8]` shows `rx_rd_ptr`, `reg_rdata[24:16]` shows `tx_rd_ptr`, `reg_rdata[29:25]` shows `rx_head_seq`, and bits 12 to 15, 30 and 31 read 0.
- R7: `irq` is high when any of these hold: bit 0 is set and `dma_ctrl[0]` is 1; bit 1 is set; bit 5 is set and `dma_ctrl[9]` is 1; any error group bit (2, 3, 4, 6 or 7) is set.
- R8: `dma_halt` is high exactly while at least one of status bits 3, 4 or 7 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_tx_empty | input | 1 | Transmit ring empty pulse |
| evt_tx_pkt | input | 1 | Transmit packet with interrupt request sent |
| evt_link_fail | input | 1 | Link failure pulse |
| evt_mem_err | input | 1 | DMA memory error pulse |
| evt_tx_abort | input | 1 | Transmit abort pulse |
| evt_rx_underflow | input | 1 | Receive underflow pulse |
| evt_rx_overflow | input | 1 | Receive overflow pulse |
| rx_fifo_count | input | 5 | Current receive FIFO entry count |
| rx_rd_ptr | input | 4 | Receive FIFO read pointer |
| tx_rd_ptr | input | 9 | Transmit ring read pointer |
| rx_head_seq | input | 5 | Sequence number of head receive message |
| dma_ctrl | input | 16 | DMA control word (enables, depth field) |
| reg_wr_en | input | 1 | Write strobe for the status register |
| reg_wdata | input | 32 | Write data; 1 bits clear status |
| reg_rdata | output | 32 | Read word: status plus pointer aliases |
| irq | output | 1 | Interrupt line |
| dma_halt | output | 1 | Stop request for DMA on a fatal condition |

## Verification
The hardest state to reach is a set status bit colliding with a clearing write in the same cycle, and doing so for the threshold bit, which has no pulse input. The stimulus moves the FIFO count away from the programmed depth for exactly the cycle of an all-ones write, then restores equality. Each bit then gets the same collision in turn. A sweep over all 256 clear masks and all four enable combinations starts from a fully set word, so every mix of remaining bits is checked against the interrupt and halt formulas.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
   localparam int EVT_N        = 8;
   localparam int EV_TX_EMPTY  = 0;
   localparam int EV_TX_PKT    = 1;
   localparam int EV_LINK_FAIL = 2;
   localparam int EV_MEM_ERR   = 3;
   localparam int EV_TX_ABORT  = 4;
   localparam int EV_RX_THRESH = 5;
   localparam int EV_RX_UNDER  = 6;
   localparam int EV_RX_OVER   = 7;

   localparam logic [EVT_N-1:0] FATAL_MASK =
      (EVT_N'(1) << EV_MEM_ERR) | (EVT_N'(1) << EV_TX_ABORT) | (EVT_N'(1) << EV_RX_OVER);
   localparam logic [EVT_N-1:0] ERROR_MASK =
      FATAL_MASK | (EVT_N'(1) << EV_LINK_FAIL) | (EVT_N'(1) << EV_RX_UNDER);
   localparam logic [EVT_N-1:0] ALWAYS_MASK = ERROR_MASK | (EVT_N'(1) << EV_TX_PKT);
endpackage

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);
   for (genvar b = 0; b < N; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)
            q_o[b] <= 1'b0;
         else if (set_i[b])
            q_o[b] <= 1'b1;
         else if (clr_i[b])
            q_o[b] <= 1'b0;
      end

      assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[b] && !set_i[b]) |=> !q_o[b]);
      assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[b] |=> q_o[b]);
      assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (!set_i[b] && !clr_i[b]) |=> $stable(q_o[b]));
   end
endmodule

// File: rtl/irq_thresh_cmp.sv
module irq_thresh_cmp #(
   parameter int CNT_W = 5
) (
   input  logic [CNT_W-1:0] count_i,
   input  logic [CNT_W-1:0] depth_i,
   output logic             hit_o
);
   always_comb hit_o = (count_i != depth_i);
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
   parameter int DATA_W     = 32,
   parameter int EVT_N      = 8,
   parameter int RX_PTR_W   = 4,
   parameter int RX_PTR_LSB = 8,
   parameter int TX_PTR_W   = 9,
   parameter int TX_PTR_LSB = 16,
   parameter int SEQ_W      = 5,
   parameter int SEQ_LSB    = 25
) (
   input  logic [EVT_N-1:0]    status_i,
   input  logic [RX_PTR_W-1:0] rx_ptr_i,
   input  logic [TX_PTR_W-1:0] tx_ptr_i,
   input  logic [SEQ_W-1:0]    seq_i,
   output logic [DATA_W-1:0]   word_o
);
   always_comb begin
      word_o = '0;
      word_o[EVT_N-1:0]                = status_i;
      word_o[RX_PTR_LSB +: RX_PTR_W]   = rx_ptr_i;
      word_o[TX_PTR_LSB +: TX_PTR_W]   = tx_ptr_i;
      word_o[SEQ_LSB +: SEQ_W]         = seq_i;
   end
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen
   import irq_stat_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_N-1:0] status_i,
   input  logic             tx_empty_en_i,
   input  logic             rx_thresh_en_i,
   output logic             irq_o,
   output logic             halt_o
);
   logic [EVT_N-1:0] en_vec;
   logic             irq_next;

   always_comb begin
      en_vec               = ALWAYS_MASK;
      en_vec[EV_TX_EMPTY]  = tx_empty_en_i;
      en_vec[EV_RX_THRESH] = rx_thresh_en_i;
      irq_next             = |(status_i & en_vec);
      halt_o               = |(status_i & FATAL_MASK);
   end

   if (IRQ_REG) begin : g_irq_flop
      always_ff @(posedge clk) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= irq_next;
      end
   end else begin : g_irq_comb
      always_comb irq_o = irq_next;

      assert_quiet_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (status_i == '0) |-> !irq_o);
      assert_error_reaches_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
         ((status_i & ERROR_MASK) != '0) |-> irq_o);
   end
endmodule

// File: rtl/irq_status_ctl.sv
module irq_status_ctl
   import irq_stat_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int CTRL_W      = 16,
   parameter int CNT_W       = 5,
   parameter int DEPTH_LSB   = 4,
   parameter int TXE_EN_BIT  = 0,
   parameter int RXT_EN_BIT  = 9,
   parameter int RX_PTR_W    = 4,
   parameter int RX_PTR_LSB  = 8,
   parameter int TX_PTR_W    = 9,
   parameter int TX_PTR_LSB  = 16,
   parameter int SEQ_W       = 5,
   parameter int SEQ_LSB     = 25,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                evt_tx_empty,
   input  logic                evt_tx_pkt,
   input  logic                evt_link_fail,
   input  logic                evt_mem_err,
   input  logic                evt_tx_abort,
   input  logic                evt_rx_underflow,
   input  logic                evt_rx_overflow,
   input  logic [CNT_W-1:0]    rx_fifo_count,
   input  logic [RX_PTR_W-1:0] rx_rd_ptr,
   input  logic [TX_PTR_W-1:0] tx_rd_ptr,
   input  logic [SEQ_W-1:0]    rx_head_seq,
   input  logic [CTRL_W-1:0]   dma_ctrl,
   input  logic                reg_wr_en,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic                irq,
   output logic                dma_halt
);
   localparam int RX_PTR_TOP = RX_PTR_LSB + RX_PTR_W;
   localparam int TX_PTR_TOP = TX_PTR_LSB + TX_PTR_W;
   localparam int SEQ_TOP    = SEQ_LSB + SEQ_W;
   localparam int DEPTH_TOP  = DEPTH_LSB + CNT_W;

   if (RX_PTR_LSB < EVT_N)        begin : g_chk_rx  $error("rx pointer alias overlaps status"); end
   if (RX_PTR_TOP > TX_PTR_LSB)   begin : g_chk_tx  $error("rx and tx pointer aliases overlap"); end
   if (TX_PTR_TOP > SEQ_LSB)      begin : g_chk_seq $error("tx pointer and sequence overlap"); end
   if (SEQ_TOP > DATA_W)          begin : g_chk_dw  $error("read word too narrow"); end
   if (DEPTH_TOP > CTRL_W)        begin : g_chk_dep $error("depth field outside control word"); end
   if (TXE_EN_BIT >= CTRL_W || RXT_EN_BIT >= CTRL_W) begin : g_chk_en
      $error("enable bit outside control word");
   end
   if ((TXE_EN_BIT >= DEPTH_LSB && TXE_EN_BIT < DEPTH_TOP) ||
       (RXT_EN_BIT >= DEPTH_LSB && RXT_EN_BIT < DEPTH_TOP)) begin : g_chk_ov
      $error("enable bit inside depth field");
   end

   logic [EVT_N-1:0] set_vec;
   logic [EVT_N-1:0] clr_vec;
   logic [EVT_N-1:0] status;
   logic             thresh_hit;
   logic             unused_bits;

   assign unused_bits = ^{dma_ctrl, reg_wdata};

   irq_thresh_cmp #(.CNT_W(CNT_W)) i_thresh (
      .count_i (rx_fifo_count),
      .depth_i (dma_ctrl[DEPTH_LSB +: CNT_W]),
      .hit_o   (thresh_hit)
   );

   always_comb begin
      set_vec               = '0;
      set_vec[EV_TX_EMPTY]  = evt_tx_empty;
      set_vec[EV_TX_PKT]    = evt_tx_pkt;
      set_vec[EV_LINK_FAIL] = evt_link_fail;
      set_vec[EV_MEM_ERR]   = evt_mem_err;
      set_vec[EV_TX_ABORT]  = evt_tx_abort;
      set_vec[EV_RX_THRESH] = thresh_hit;
      set_vec[EV_RX_UNDER]  = evt_rx_underflow;
      set_vec[EV_RX_OVER]   = evt_rx_overflow;
      clr_vec               = {EVT_N{reg_wr_en}} & reg_wdata[EVT_N-1:0];
   end

   irq_w1c_bank #(.N(EVT_N)) i_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec),
      .clr_i (clr_vec),
      .q_o   (status)
   );

   irq_read_mux #(
      .DATA_W     (DATA_W),
      .EVT_N      (EVT_N),
      .RX_PTR_W   (RX_PTR_W),
      .RX_PTR_LSB (RX_PTR_LSB),
      .TX_PTR_W   (TX_PTR_W),
      .TX_PTR_LSB (TX_PTR_LSB),
      .SEQ_W      (SEQ_W),
      .SEQ_LSB    (SEQ_LSB)
   ) i_rmux (
      .status_i (status),
      .rx_ptr_i (rx_rd_ptr),
      .tx_ptr_i (tx_rd_ptr),
      .seq_i    (rx_head_seq),
      .word_o   (reg_rdata)
   );

   irq_line_gen #(.IRQ_REG(IRQ_REG)) i_line (
      .clk            (clk),
      .rst_n          (rst_n),
      .status_i       (status),
      .tx_empty_en_i  (dma_ctrl[TXE_EN_BIT]),
      .rx_thresh_en_i (dma_ctrl[RXT_EN_BIT]),
      .irq_o          (irq),
      .halt_o         (dma_halt)
   );

   assert_thresh_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_fifo_count != dma_ctrl[DEPTH_LSB +: CNT_W]) |=> reg_rdata[EV_RX_THRESH]);
   assert_fatal_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_mem_err || evt_tx_abort || evt_rx_overflow) |=> dma_halt);
   assert_halt_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && (reg_wdata[EVT_N-1:0] == '1) && !evt_mem_err && !evt_tx_abort &&
       !evt_rx_overflow) |=> !dma_halt);
   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (reg_rdata[EVT_N-1:0] == '0));
endmodule

// File: tb/test_irq_status_ctl.sv
`timescale 1ns/1ps
module test_irq_status_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  ev = '0;
   logic [4:0]  cnt = '0;
   logic [3:0]  rxp = '0;
   logic [8:0]  txp = '0;
   logic [4:0]  seq = '0;
   logic [15:0] ctrl = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   logic        halt;
   int          n_chk = 0;
   int          n_bad = 0;

   always #2.5 clk = ~clk;

   irq_status_ctl i_irq_status_ctl (
      .clk              (clk),
      .rst_n            (rst_n),
      .evt_tx_empty     (ev[0]),
      .evt_tx_pkt       (ev[1]),
      .evt_link_fail    (ev[2]),
      .evt_mem_err      (ev[3]),
      .evt_tx_abort     (ev[4]),
      .evt_rx_underflow (ev[6]),
      .evt_rx_overflow  (ev[7]),
      .rx_fifo_count    (cnt),
      .rx_rd_ptr        (rxp),
      .tx_rd_ptr        (txp),
      .rx_head_seq      (seq),
      .dma_ctrl         (ctrl),
      .reg_wr_en        (wr),
      .reg_wdata        (wdata),
      .reg_rdata        (rdata),
      .irq              (irq),
      .dma_halt         (halt)
   );

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic clear_all();
      wr = 1'b1;
      wdata = 32'h0000_00FF;
      cyc();
      wr = 1'b0;
      wdata = '0;
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] st;
      logic [7:0] en;
      // R1: reset state
      cyc(); cyc();
      chk("R1 status in reset", {24'd0, rdata[7:0]}, 32'd0);
      chk("R1 irq in reset", {31'd0, irq}, 32'd0);
      chk("R1 halt in reset", {31'd0, halt}, 32'd0);
      rst_n = 1'b1;
      cyc();
      chk("R1 status after reset", {24'd0, rdata[7:0]}, 32'd0);

      // R3, R7, R8: every clear mask from a full word, every enable pair
      for (int m = 0; m < 256; m++) begin
         for (int e = 0; e < 4; e++) begin
            ctrl = '0;
            ctrl[0] = e[0];
            ctrl[9] = e[1];
            ev = 8'hDF;
            cnt = 5'd1;
            cyc();
            ev = '0;
            cnt = 5'd0;
            wr = 1'b1;
            wdata = 32'(m);
            cyc();
            wr = 1'b0;
            wdata = '0;
            st = ~8'(m);
            en = 8'hDE | {2'b00, e[1], 4'b0000, e[0]};
            chk("R3 clear mask", {24'd0, rdata[7:0]}, {24'd0, st});
            chk("R7 irq", {31'd0, irq}, {31'd0, |(st & en)});
            chk("R8 halt", {31'd0, halt}, {31'd0, |(st & 8'h98)});
            clear_all();
         end
      end
      ctrl = '0;

      // R2: each event alone sets its bit and it stays
      for (int i = 0; i < 8; i++) begin
         clear_all();
         if (i == 5) cnt = 5'd3; else ev[i] = 1'b1;
         cyc();
         ev = '0;
         cnt = 5'd0;
         cyc(); cyc(); cyc();
         chk("R2 sticky bit", {24'd0, rdata[7:0]}, 32'd1 << i);
      end

      // R4: event wins over same-cycle clear of all bits
      for (int i = 0; i < 8; i++) begin
         ev = 8'hDF;
         cnt = 5'd1;
         cyc();
         ev = '0;
         cnt = 5'd0;
         if (i == 5) cnt = 5'd9; else ev[i] = 1'b1;
         wr = 1'b1;
         wdata = 32'hFFFF_FFFF;
         cyc();
         wr = 1'b0;
         wdata = '0;
         ev = '0;
         cnt = 5'd0;
         chk("R4 event beats clear", {24'd0, rdata[7:0]}, 32'd1 << i);
      end

      // R5: threshold against several depths over every count
      for (int d = 0; d < 3; d++) begin
         logic [4:0] dep;
         dep = (d == 0) ? 5'd0 : (d == 1) ? 5'd7 : 5'd31;
         ctrl = '0;
         ctrl[8:4] = dep;
         for (int c = 0; c < 32; c++) begin
            cnt = dep;
            clear_all();
            cnt = 5'(c);
            cyc();
            cnt = dep;
            chk("R5 threshold", {31'd0, rdata[5]}, {31'd0, (5'(c) != dep)});
         end
      end
      ctrl = '0;
      cnt = '0;
      clear_all();

      // R6: pointer and sequence aliases, reserved bits zero
      for (int k = 0; k < 64; k++) begin
         logic [31:0] exp;
         rxp = 4'((k * 7) % 16);
         txp = 9'((k * 37 + 5) % 512);
         seq = 5'((k * 11 + 3) % 32);
         #1;
         exp = (32'(rxp) << 8) | (32'(txp) << 16) | (32'(seq) << 25);
         chk("R6 read aliases", {rdata[31:8], 8'd0}, exp);
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule